// File: doc/BRIEF.md
# JTAG Shutdown-Readback Command Sequencer

This block sits on the host side of a JTAG link. After a single start pulse it drives the test clock, mode select and data-in lines. It takes the target's TAP through a fixed run of steps and then stops with the TAP parked in Run-Test/Idle. The steps are:

1. Reset the TAP.
2. Load the 10-bit configuration-input instruction.
3. Shift a short list of 32-bit configuration packets that prepare a readback.
4. Load the 10-bit shutdown instruction.
5. Move the TAP back to idle.

The test clock is the system clock divided by an even ratio, and it is held low while the block is idle. Mode select and data-in change only as the test clock falls. TDO is sampled as the test clock rises. Every bit sampled in a shift state is passed on through a one-cycle valid strobe with its data bit. Software or a controller starts a run with `start`, watches `busy`, and gets a one-cycle `done` pulse at the end. A new run may begin in the same cycle as that pulse.

Top module: `jtag_rdbk_seq`

## Requirements
- R1: After reset, busy, done, tck, tms, tdi and cap_valid are all 0.
- R2: A start pulse while idle makes busy 1 from the next clock. A start pulse while busy has no effect: the run keeps its length and its TMS/TDI stream.
- R3: Every TCK period lasts DIV system clocks, with TCK high for DIV/2 of them. TMS and TDI do not change while TCK is high.
- R4: The first five TCK cycles carry TMS=1, to reach Test-Logic-Reset. The sixth carries TMS=0, to reach Run-Test/Idle.
- R5: The next four TCK cycles carry TMS 1,1,0,0, which reaches Shift-IR.
- R6: Each instruction is 10 bits, sent least significant bit first. TMS is 0 for bits 0..8 and 1 for bit 9. The first instruction is 0x3C5 (binary 1111000101) and the second is 0x3C6 (binary 1111000110).
- R7: After the first instruction, four TCK cycles carry TMS 1,1,0,0, which reaches Shift-DR.
- R8: Seven packets are shifted in the order 0xFFFFFFFF, 0xAA995566, 0x20000000, 0x30008001, 0x00000007, 0x20000000, 0x20000000. Each packet goes out most significant bit first, 224 bits in all. TMS is 1 only on the last bit.
- R9: The data shift is followed by five TCK cycles with TMS 1,1,1,0,0, then the second instruction, then two cycles with TMS 1,0. A run is 265 TCK cycles in total.
- R10: done is a one-clock pulse that starts in the same cycle that busy falls, after the last TCK cycle. A start in the done cycle is accepted.
- R11: cap_valid pulses for one clock at each TCK rise during the 244 shift-state bits and at no other time. cap_bit equals TDO at that rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a run (one clock) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock end-of-run pulse |
| tck | output | 1 | Test clock to target |
| tms | output | 1 | Test mode select to target |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |
| cap_valid | output | 1 | Captured bit strobe |
| cap_bit | output | 1 | Captured TDO bit |

## Verification
The end of one run and the start of the next can land in the same clock, because `start` may arrive in the very cycle that `done` is high. The bench provokes this by raising `start` as soon as it sees `done`. It then checks that `busy` returns on the next clock and that the second run repeats all 265 TCK steps exactly. A second case sends a start pulse in the middle of a run. The bench judges that case by the step count and the bit stream being unchanged.

// File: rtl/jtag_rdbk_pkg.sv
package jtag_rdbk_pkg;
   localparam int PKT_W   = 32;
   localparam int NPKT    = 7;
   localparam int DR_BITS = PKT_W * NPKT;

   typedef enum logic [3:0] {
      PH_IDLE, PH_RST, PH_RTI, PH_TO_IR1, PH_IR1,
      PH_TO_DR, PH_DR, PH_TO_IR2, PH_IR2, PH_TO_RTI
   } phase_t;
endpackage

// File: rtl/rdbk_tck_gen.sv
module rdbk_tck_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tck,
   output logic rise,
   output logic fall
);
   localparam int HALF = DIV / 2;
   localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

   if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
      $error("DIV must be an even value of at least 2");
   end

   logic [CW-1:0] cnt;

   assign rise = run && (cnt == CW'(HALF - 1));
   assign fall = run && (cnt == CW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         tck <= 1'b0;
      end else if (!run) begin
         cnt <= '0;
         tck <= 1'b0;
      end else begin
         cnt <= fall ? '0 : cnt + 1'b1;
         if (rise)      tck <= 1'b1;
         else if (fall) tck <= 1'b0;
      end
   end

   AST_TCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(run) |-> !tck); // R3
endmodule

// File: rtl/rdbk_pkt_rom.sv
module rdbk_pkt_rom
   import jtag_rdbk_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic [AW-1:0]    addr,
   output logic [PKT_W-1:0] word
);
   if ((1 << AW) < NPKT) begin : g_bad_aw
      $error("packet ROM address too narrow");
   end

   always_comb begin
      case (addr)
         AW'(0):  word = 32'hFFFF_FFFF;
         AW'(1):  word = 32'hAA99_5566;
         AW'(2):  word = 32'h2000_0000;
         AW'(3):  word = 32'h3000_8001;
         AW'(4):  word = 32'h0000_0007;
         AW'(5):  word = 32'h2000_0000;
         AW'(6):  word = 32'h2000_0000;
         default: word = '0;
      endcase
   end
endmodule

// File: rtl/rdbk_seq.sv
module rdbk_seq
   import jtag_rdbk_pkg::*;
#(
   parameter int              IR_W    = 10,
   parameter logic [IR_W-1:0] IR_CFG  = 10'h3C5,
   parameter logic [IR_W-1:0] IR_SHUT = 10'h3C6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic fall,
   output logic busy,
   output logic done,
   output logic tms,
   output logic tdi,
   output logic shifting
);
   localparam int IW  = $clog2(DR_BITS);
   localparam int BW  = $clog2(PKT_W);
   localparam int RAW = IW - BW;
   localparam int IRB = $clog2(IR_W);

   if (IR_W > DR_BITS || IR_W < 2) begin : g_bad_ir
      $error("IR_W out of range");
   end

   phase_t         phase, nphase;
   logic [IW-1:0]  idx, nidx;
   logic           last;
   logic [PKT_W-1:0] word;
   logic           ntms, ntdi;

   always_comb begin
      case (phase)
         PH_RST:    last = (idx == IW'(4));
         PH_RTI:    last = 1'b1;
         PH_TO_IR1,
         PH_TO_DR:  last = (idx == IW'(3));
         PH_IR1,
         PH_IR2:    last = (idx == IW'(IR_W - 1));
         PH_DR:     last = (idx == IW'(DR_BITS - 1));
         PH_TO_IR2: last = (idx == IW'(4));
         PH_TO_RTI: last = (idx == IW'(1));
         default:   last = 1'b1;
      endcase
   end

   always_comb begin
      nidx = last ? '0 : idx + 1'b1;
      if (!last) nphase = phase;
      else begin
         case (phase)
            PH_RST:    nphase = PH_RTI;
            PH_RTI:    nphase = PH_TO_IR1;
            PH_TO_IR1: nphase = PH_IR1;
            PH_IR1:    nphase = PH_TO_DR;
            PH_TO_DR:  nphase = PH_DR;
            PH_DR:     nphase = PH_TO_IR2;
            PH_TO_IR2: nphase = PH_IR2;
            PH_IR2:    nphase = PH_TO_RTI;
            default:   nphase = PH_IDLE;
         endcase
      end
   end

   rdbk_pkt_rom #(.AW(RAW)) u_rom (
      .addr (nidx[IW-1:BW]),
      .word (word)
   );

   always_comb begin
      ntdi = 1'b0;
      case (nphase)
         PH_RST:    ntms = 1'b1;
         PH_TO_IR1,
         PH_TO_DR:  ntms = (nidx < IW'(2));
         PH_IR1: begin
            ntms = (nidx == IW'(IR_W - 1));
            ntdi = IR_CFG[nidx[IRB-1:0]];
         end
         PH_DR: begin
            ntms = (nidx == IW'(DR_BITS - 1));
            ntdi = word[~nidx[BW-1:0]];
         end
         PH_TO_IR2: ntms = (nidx < IW'(3));
         PH_IR2: begin
            ntms = (nidx == IW'(IR_W - 1));
            ntdi = IR_SHUT[nidx[IRB-1:0]];
         end
         PH_TO_RTI: ntms = (nidx == IW'(0));
         default:   ntms = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         idx   <= '0;
         tms   <= 1'b0;
         tdi   <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (phase == PH_IDLE) begin
            if (start) begin
               phase <= PH_RST;
               idx   <= '0;
               tms   <= 1'b1;
               tdi   <= 1'b0;
            end
         end else if (fall) begin
            phase <= nphase;
            idx   <= nidx;
            tms   <= ntms;
            tdi   <= ntdi;
            done  <= (nphase == PH_IDLE);
         end
      end
   end

   assign busy     = (phase != PH_IDLE);
   assign shifting = (phase == PH_IR1) || (phase == PH_DR) || (phase == PH_IR2);

   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !fall) |=> (busy && $stable(phase) && $stable(idx))); // R2
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy)); // R10
endmodule

// File: rtl/jtag_rdbk_seq.sv
module jtag_rdbk_seq #(
   parameter int          DIV     = 4,
   parameter int          IR_W    = 10,
   parameter logic [IR_W-1:0] IR_CFG  = 10'h3C5,
   parameter logic [IR_W-1:0] IR_SHUT = 10'h3C6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic tck,
   output logic tms,
   output logic tdi,
   input  logic tdo,
   output logic cap_valid,
   output logic cap_bit
);
   logic rise, fall, shifting;

   rdbk_tck_gen #(.DIV(DIV)) u_tck (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .tck  (tck),
      .rise (rise),
      .fall (fall)
   );

   rdbk_seq #(.IR_W(IR_W), .IR_CFG(IR_CFG), .IR_SHUT(IR_SHUT)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .fall    (fall),
      .busy    (busy),
      .done    (done),
      .tms     (tms),
      .tdi     (tdi),
      .shifting(shifting)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_valid <= 1'b0;
         cap_bit   <= 1'b0;
      end else begin
         cap_valid <= rise && shifting;
         if (rise) cap_bit <= tdo;
      end
   end

   AST_TMS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi))); // R3
   AST_CAP_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid |-> $rose(tck)); // R11
   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
endmodule

// File: tb/jtag_rdbk_seq_test.sv
module jtag_rdbk_seq_test;
   localparam int DIV   = 4;
   localparam int STEPS = 265;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic tdo = 1'b0;
   logic busy, done, tck, tms, tdi, cap_valid, cap_bit;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   jtag_rdbk_seq #(.DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
      .cap_valid(cap_valid), .cap_bit(cap_bit)
   );

   logic [31:0] pkts [7];
   initial begin
      pkts[0] = 32'hFFFFFFFF; pkts[1] = 32'hAA995566; pkts[2] = 32'h20000000;
      pkts[3] = 32'h30008001; pkts[4] = 32'h00000007; pkts[5] = 32'h20000000;
      pkts[6] = 32'h20000000;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic tdo_pat(input int k);
      return logic'(k[0] ^ k[2] ^ k[5]);
   endfunction

   // expected {tms, tdi, shift, req-group} for step k
   task automatic expect_step(input int k, output logic etms, output logic etdi,
                              output logic esh, output string req);
      etdi = 1'b0; esh = 1'b0;
      if (k < 5)        begin etms = 1'b1; req = "R4"; end
      else if (k == 5)  begin etms = 1'b0; req = "R4"; end
      else if (k < 10)  begin etms = (k < 8); req = "R5"; end
      else if (k < 20)  begin
         etms = (k == 19); etdi = 10'h3C5 >> (k - 10); esh = 1'b1; req = "R6";
      end
      else if (k < 24)  begin etms = (k < 22); req = "R7"; end
      else if (k < 248) begin
         int b;
         b = k - 24;
         etms = (k == 247); etdi = pkts[b / 32][31 - (b % 32)]; esh = 1'b1; req = "R8";
      end
      else if (k < 253) begin etms = (k < 251); req = "R9"; end
      else if (k < 263) begin
         etms = (k == 262); etdi = 10'h3C6 >> (k - 253); esh = 1'b1; req = "R6";
      end
      else begin etms = (k == 263); req = "R9"; end
   endtask

   // Monitor one run already accepted; returns at the negedge where done is seen.
   task automatic run_and_check(input bit poke_busy);
      int k = 0, cyc = 0, hi = 0, caps = 0;
      logic ptck = 1'b0, ptms, ptdi;
      logic etms, etdi, esh;
      string req;
      ptms = tms; ptdi = tdi;
      forever begin
         @(negedge clk);
         start = 1'b0;
         cyc++;
         if (tck && !ptck) begin
            if (k > 0) chk(cyc == DIV, "R3 period", cyc, DIV);
            cyc = 0; hi = 0;
            if (k < STEPS) begin
               expect_step(k, etms, etdi, esh, req);
               chk(tms == etms, {req, " tms"}, int'(tms), int'(etms));
               chk(tdi == etdi, {req, " tdi"}, int'(tdi), int'(etdi));
               chk(cap_valid == esh, "R11 valid", int'(cap_valid), int'(esh));
               if (esh) begin
                  chk(cap_bit == tdo, "R11 bit", int'(cap_bit), int'(tdo));
                  caps++;
               end
            end
            k++;
            if (poke_busy && k == 100) start = 1'b1;   // R2: ignored while busy
         end else if (cap_valid) begin
            chk(1'b0, "R11 stray valid", 1, 0);
         end
         if (tck) hi++;
         if (!tck && ptck) begin
            chk(hi == DIV / 2, "R3 high time", hi, DIV / 2);
            tdo = tdo_pat(k);
         end
         if (tck && ptck && (tms != ptms || tdi != ptdi))
            chk(1'b0, "R3 change while high", 1, 0);
         ptck = tck; ptms = tms; ptdi = tdi;
         if (done) begin
            chk(k == STEPS, "R9 step count", k, STEPS);
            chk(caps == 244, "R11 capture count", caps, 244);
            chk(busy == 1'b0, "R10 busy low at done", int'(busy), 0);
            chk(tck == 1'b0, "R3 tck low at end", int'(tck), 0);
            return;
         end
      end
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk({busy, done, tck, tms, tdi, cap_valid} == 6'b0, "R1 reset state",
          int'({busy, done, tck, tms, tdi, cap_valid}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, "R1 idle after reset", int'(busy), 0);
   endtask

   task automatic t_first_run;
      tdo = tdo_pat(0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      run_and_check(1'b1);
   endtask

   task automatic t_restart_on_done;
      // done is high at this negedge: start in the same cycle
      tdo = tdo_pat(0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
      chk(busy == 1'b1, "R10 start in done cycle accepted", int'(busy), 1);
      run_and_check(1'b0);
   endtask

   task automatic t_idle_after;
      int edges = 0;
      @(negedge clk);
      chk(done == 1'b0, "R10 done pulse width", int'(done), 0);
      repeat (20) begin
         @(negedge clk);
         if (tck || cap_valid || busy) edges++;
      end
      chk(edges == 0, "R2 quiet while idle", edges, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_first_run();
      t_restart_on_done();
      t_idle_after();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule